// File: doc/BRIEF.md
# CRT Timing Register Encoder

This block converts a display mode, given in pixels and lines, into the twelve numeric values that a CRT controller's timing fields expect. The inputs are the active width and height, the margins on each side, the sync pulse lengths, one scale factor (multiplier over divisor) per axis, a horizontal border adjustment and the two sync polarities. Horizontal quantities are counted in character clocks of 8 pixels, and vertical quantities are counted in lines.

A pulse on the start input captures all inputs. The block then runs eight scaled divisions through one shared iterative divider, encodes the results, and checks each encoded field against its own configurable width. It raises done for one cycle. If every check passes, the field outputs and the polarity byte take the new values. If any check fails, the invalid flag is set and the previous outputs are kept. Spreading these values over the physical register bits is left to the consumer.

Top module: `crt_timing_encoder`

## Requirements
- R1: While reset is asserted and after it is released, done, busy and invalid read 0, and every field output and the polarity byte read 0.
- R2: The active width, both horizontal margins and the horizontal sync length are each rounded up to the next multiple of 8 before any sum is formed. Vertical inputs are used unrounded.
- R3: The horizontal total field equals floor(floor(H*hmul/hdiv)/8) - 5, where H is the sum of the rounded width, left margin, right margin and sync length.
- R4: Let D = floor(floor(width*hmul/hdiv)/8). Horizontal display is D-1 and blank start is D-1+border. Blank end is floor(floor(H*hmul/hdiv)/8)-1-border.
- R5: Horizontal sync start is floor(floor((width+right)*hmul/hdiv)/8). Sync end uses the same formula on width+right+sync length.
- R6: With S(x) = floor(x*vmul/vdiv), the fields are: vertical total = S(V)-2, display = S(height)-1, blank start = S(height), and blank end = S(V)-2. Here V is height+upper+lower+vsync length.
- R7: Vertical sync start is S(height+lower) and vertical sync end is S(height+lower+vsync length).
- R8: A run is invalid when the horizontal blanking length (left+right+sync), the horizontal sync length, the vertical blanking length (upper+lower+vsync) or the vertical sync length is zero.
- R9: A run is invalid when any encoded field is negative or is at least 2 to the power of that field's configured width.
- R10: After an invalid run, every field output and the polarity byte keep the values they held before that run.
- R11: In the polarity byte, bit 7 is 0 for active-high horizontal sync and 1 for active-low horizontal sync. Bit 6 follows the same rule for vertical sync. Bits 5..0 are 0.
- R12: A zero horizontal or vertical divisor makes the run invalid.
- R13: Start is accepted only while busy is low. Busy then stays high until done, and done is high for exactly one cycle per accepted start. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture the inputs and begin a conversion |
| xres_i | input | IN_W | Active width in pixels |
| hleft_i | input | IN_W | Left margin in pixels |
| hright_i | input | IN_W | Right margin in pixels |
| hsync_len_i | input | IN_W | Horizontal sync length in pixels |
| yres_i | input | IN_W | Active height in lines |
| vupper_i | input | IN_W | Upper margin in lines |
| vlower_i | input | IN_W | Lower margin in lines |
| vsync_len_i | input | IN_W | Vertical sync length in lines |
| hmul_i | input | MUL_W | Horizontal scale multiplier |
| hdiv_i | input | MUL_W | Horizontal scale divisor |
| vmul_i | input | MUL_W | Vertical scale multiplier |
| vdiv_i | input | MUL_W | Vertical scale divisor |
| hborder_i | input | BRD_W | Horizontal border adjustment in character clocks |
| hsync_pos_i | input | 1 | 1 = horizontal sync active high |
| vsync_pos_i | input | 1 | 1 = vertical sync active high |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| invalid_o | output | 1 | Last run failed validation |
| h_total_o | output | OUT_W | Horizontal total field |
| h_disp_o | output | OUT_W | Horizontal display end field |
| h_bstart_o | output | OUT_W | Horizontal blank start field |
| h_bend_o | output | OUT_W | Horizontal blank end field |
| h_sstart_o | output | OUT_W | Horizontal sync start field |
| h_send_o | output | OUT_W | Horizontal sync end field |
| v_total_o | output | OUT_W | Vertical total field |
| v_disp_o | output | OUT_W | Vertical display end field |
| v_bstart_o | output | OUT_W | Vertical blank start field |
| v_bend_o | output | OUT_W | Vertical blank end field |
| v_sstart_o | output | OUT_W | Vertical sync start field |
| v_send_o | output | OUT_W | Vertical sync end field |
| pol_o | output | 8 | Sync polarity byte |

## Verification
The bench builds the block with 10-bit inputs, 3-bit scale factors, 7-bit horizontal fields and 9-bit vertical fields, and a 9-bit output width. At that size a few hundred pixels are enough to overflow a horizontal field. Small totals push the horizontal total below zero, and a zero divisor fits in the 3-bit range. One sweep therefore mixes valid runs with every kind of rejection, including runs with non-multiple-of-8 widths and border adjustments that only just fit.

// File: rtl/ctenc_pkg.sv
package ctenc_pkg;
  localparam int unsigned NUM_FIELDS = 12;
  localparam int unsigned NUM_DIVS   = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_EVAL
  } ctenc_state_e;
endpackage

// File: rtl/ctenc_divider.sv
module ctenc_divider #(
  parameter int unsigned NUM_W = 16,
  parameter int unsigned DEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem_q, rem_sh, rem_nx;
  logic [NUM_W-1:0] quot_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q, take;

  // restoring step: bring in next numerator bit, subtract if it fits
  always_comb begin
    rem_sh = {rem_q[DEN_W-1:0], quot_q[NUM_W-1]};
    take   = rem_sh >= {1'b0, den_q};
    rem_nx = take ? rem_sh - {1'b0, den_q} : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quot_q <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        quot_q <= num_i;
        rem_q  <= '0;
        den_q  <= den_i;
        cnt_q  <= CNT_W'(NUM_W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        quot_q <= {quot_q[NUM_W-2:0], take};
        rem_q  <= rem_nx;
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quot_q;
endmodule

// File: rtl/ctenc_range_check.sv
module ctenc_range_check #(
  parameter int unsigned NF    = 12,
  parameter int unsigned ENC_W = 18,
  parameter int unsigned FLD_W [NF] = '{8, 8, 8, 8, 8, 8, 10, 10, 10, 10, 10, 10}
) (
  input  logic [NF-1:0][ENC_W-1:0] enc_i,
  output logic                     fail_o
);
  logic [NF-1:0] fail;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    localparam logic [ENC_W-1:0] LIMIT = ENC_W'(1) << FLD_W[g];
    // top bit set means the encoding went below zero
    assign fail[g] = enc_i[g][ENC_W-1] || (enc_i[g] >= LIMIT);
  end

  assign fail_o = |fail;
endmodule

// File: rtl/crt_timing_encoder.sv
module crt_timing_encoder
  import ctenc_pkg::*;
#(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned MUL_W = 4,
  parameter int unsigned BRD_W = 3,
  parameter int unsigned OUT_W = 10,
  parameter int unsigned FLD_W [12] = '{8, 8, 8, 8, 8, 8, 10, 10, 10, 10, 10, 10}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IN_W-1:0]  xres_i,
  input  logic [IN_W-1:0]  hleft_i,
  input  logic [IN_W-1:0]  hright_i,
  input  logic [IN_W-1:0]  hsync_len_i,
  input  logic [IN_W-1:0]  yres_i,
  input  logic [IN_W-1:0]  vupper_i,
  input  logic [IN_W-1:0]  vlower_i,
  input  logic [IN_W-1:0]  vsync_len_i,
  input  logic [MUL_W-1:0] hmul_i,
  input  logic [MUL_W-1:0] hdiv_i,
  input  logic [MUL_W-1:0] vmul_i,
  input  logic [MUL_W-1:0] vdiv_i,
  input  logic [BRD_W-1:0] hborder_i,
  input  logic             hsync_pos_i,
  input  logic             vsync_pos_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             invalid_o,
  output logic [OUT_W-1:0] h_total_o,
  output logic [OUT_W-1:0] h_disp_o,
  output logic [OUT_W-1:0] h_bstart_o,
  output logic [OUT_W-1:0] h_bend_o,
  output logic [OUT_W-1:0] h_sstart_o,
  output logic [OUT_W-1:0] h_send_o,
  output logic [OUT_W-1:0] v_total_o,
  output logic [OUT_W-1:0] v_disp_o,
  output logic [OUT_W-1:0] v_bstart_o,
  output logic [OUT_W-1:0] v_bend_o,
  output logic [OUT_W-1:0] v_sstart_o,
  output logic [OUT_W-1:0] v_send_o,
  output logic [7:0]       pol_o
);
  localparam int unsigned SUM_W = IN_W + 3;
  localparam int unsigned NUM_W = SUM_W + MUL_W;
  localparam int unsigned ENC_W = NUM_W + 2;
  localparam int unsigned IDX_W = $clog2(NUM_DIVS);

  ctenc_state_e state_q;
  logic [IDX_W-1:0] idx_q;

  // captured and rounded inputs
  logic [SUM_W-1:0] xr_q, hl_q, hr_q, hs_q, yr_q, vu_q, vl_q, vs_q;
  logic [MUL_W-1:0] hmul_q, hdiv_q, vmul_q, vdiv_q;
  logic [BRD_W-1:0] brd_q;
  logic             hpos_q, vpos_q;

  logic [NUM_W-1:0] quot_q [NUM_DIVS];

  logic [NUM_FIELDS-1:0][OUT_W-1:0] fld_q;
  logic [7:0] pol_q;
  logic       done_q, inval_q;

  function automatic logic [SUM_W-1:0] round8(input logic [IN_W-1:0] v);
    return ({3'b000, v} + SUM_W'(7)) & ~SUM_W'(7);
  endfunction

  // operand select for the shared divider
  logic [SUM_W-1:0] op_sum;
  logic [MUL_W-1:0] op_mul, op_den;
  logic [NUM_W-1:0] op_num;

  always_comb begin
    unique case (idx_q)
      3'd0:    op_sum = xr_q + hl_q + hr_q + hs_q;
      3'd1:    op_sum = xr_q;
      3'd2:    op_sum = xr_q + hr_q;
      3'd3:    op_sum = xr_q + hr_q + hs_q;
      3'd4:    op_sum = yr_q + vu_q + vl_q + vs_q;
      3'd5:    op_sum = yr_q;
      3'd6:    op_sum = yr_q + vl_q;
      default: op_sum = yr_q + vl_q + vs_q;
    endcase
    op_mul = idx_q[IDX_W-1] ? vmul_q : hmul_q;
    op_den = idx_q[IDX_W-1] ? vdiv_q : hdiv_q;
    op_num = NUM_W'(op_sum) * NUM_W'(op_mul);
  end

  logic             div_start, div_done;
  logic [NUM_W-1:0] div_quot;

  assign div_start = (state_q == ST_LOAD);

  ctenc_divider #(
    .NUM_W(NUM_W),
    .DEN_W(MUL_W)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (op_num),
    .den_i  (op_den),
    .done_o (div_done),
    .quot_o (div_quot)
  );

  // field encoding in two's complement; range check catches negatives
  logic [ENC_W-1:0] ht8, hd8, hss8, hse8, brd_e;
  logic [NUM_FIELDS-1:0][ENC_W-1:0] enc;

  always_comb begin
    ht8   = ENC_W'(quot_q[0] >> 3);
    hd8   = ENC_W'(quot_q[1] >> 3);
    hss8  = ENC_W'(quot_q[2] >> 3);
    hse8  = ENC_W'(quot_q[3] >> 3);
    brd_e = ENC_W'(brd_q);
    enc[0]  = ht8 - ENC_W'(5);
    enc[1]  = hd8 - ENC_W'(1);
    enc[2]  = hd8 - ENC_W'(1) + brd_e;
    enc[3]  = ht8 - ENC_W'(1) - brd_e;
    enc[4]  = hss8;
    enc[5]  = hse8;
    enc[6]  = ENC_W'(quot_q[4]) - ENC_W'(2);
    enc[7]  = ENC_W'(quot_q[5]) - ENC_W'(1);
    enc[8]  = ENC_W'(quot_q[5]);
    enc[9]  = ENC_W'(quot_q[4]) - ENC_W'(2);
    enc[10] = ENC_W'(quot_q[6]);
    enc[11] = ENC_W'(quot_q[7]);
  end

  logic range_fail, len_fail, div_zero, bad;

  ctenc_range_check #(
    .NF   (NUM_FIELDS),
    .ENC_W(ENC_W),
    .FLD_W(FLD_W)
  ) u_rng (
    .enc_i (enc),
    .fail_o(range_fail)
  );

  assign len_fail = ((hl_q + hr_q + hs_q) == '0) || (hs_q == '0) ||
                    ((vu_q + vl_q + vs_q) == '0) || (vs_q == '0);
  assign div_zero = (hdiv_q == '0) || (vdiv_q == '0);
  assign bad      = range_fail || len_fail || div_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      xr_q    <= '0;
      hl_q    <= '0;
      hr_q    <= '0;
      hs_q    <= '0;
      yr_q    <= '0;
      vu_q    <= '0;
      vl_q    <= '0;
      vs_q    <= '0;
      hmul_q  <= '0;
      hdiv_q  <= '0;
      vmul_q  <= '0;
      vdiv_q  <= '0;
      brd_q   <= '0;
      hpos_q  <= 1'b0;
      vpos_q  <= 1'b0;
      for (int i = 0; i < NUM_DIVS; i++) quot_q[i] <= '0;
      fld_q   <= '0;
      pol_q   <= '0;
      done_q  <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          xr_q    <= round8(xres_i);
          hl_q    <= round8(hleft_i);
          hr_q    <= round8(hright_i);
          hs_q    <= round8(hsync_len_i);
          yr_q    <= SUM_W'(yres_i);
          vu_q    <= SUM_W'(vupper_i);
          vl_q    <= SUM_W'(vlower_i);
          vs_q    <= SUM_W'(vsync_len_i);
          hmul_q  <= hmul_i;
          hdiv_q  <= hdiv_i;
          vmul_q  <= vmul_i;
          vdiv_q  <= vdiv_i;
          brd_q   <= hborder_i;
          hpos_q  <= hsync_pos_i;
          vpos_q  <= vsync_pos_i;
          idx_q   <= '0;
          state_q <= ST_LOAD;
        end
        ST_LOAD: state_q <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          quot_q[idx_q] <= div_quot;
          if (idx_q == IDX_W'(NUM_DIVS - 1)) begin
            state_q <= ST_EVAL;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_LOAD;
          end
        end
        default: begin
          if (!bad) begin
            for (int i = 0; i < NUM_FIELDS; i++) fld_q[i] <= enc[i][OUT_W-1:0];
            pol_q <= {~hpos_q, ~vpos_q, 6'b0};
          end
          inval_q <= bad;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign invalid_o  = inval_q;
  assign h_total_o  = fld_q[0];
  assign h_disp_o   = fld_q[1];
  assign h_bstart_o = fld_q[2];
  assign h_bend_o   = fld_q[3];
  assign h_sstart_o = fld_q[4];
  assign h_send_o   = fld_q[5];
  assign v_total_o  = fld_q[6];
  assign v_disp_o   = fld_q[7];
  assign v_bstart_o = fld_q[8];
  assign v_bend_o   = fld_q[9];
  assign v_sstart_o = fld_q[10];
  assign v_send_o   = fld_q[11];
  assign pol_o      = pol_q;
endmodule

// File: rtl/ctenc_checker.sv
module ctenc_checker #(
  parameter int unsigned OUT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             invalid_o,
  input logic [OUT_W-1:0] h_total_o,
  input logic [OUT_W-1:0] h_sstart_o,
  input logic [OUT_W-1:0] h_send_o,
  input logic [OUT_W-1:0] v_total_o,
  input logic [OUT_W-1:0] v_sstart_o,
  input logic [OUT_W-1:0] v_send_o,
  input logic [7:0]       pol_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!busy_o && !done_o && !invalid_o && pol_o == 8'h00);
    end
  end

  p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_end_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_start_take_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_hold_between_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(h_total_o) && $stable(v_total_o) && $stable(pol_o)));

  p_hold_invalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && invalid_o) |-> ($stable(h_total_o) && $stable(v_send_o) && $stable(pol_o)));

  p_pol_low_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_o[5:0] == 6'b0);

  p_hsync_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !invalid_o) |-> (h_send_o >= h_sstart_o));

  p_vsync_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !invalid_o) |-> (v_send_o >= v_sstart_o));
endmodule

bind crt_timing_encoder ctenc_checker #(
  .OUT_W(OUT_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .invalid_o (invalid_o),
  .h_total_o (h_total_o),
  .h_sstart_o(h_sstart_o),
  .h_send_o  (h_send_o),
  .v_total_o (v_total_o),
  .v_sstart_o(v_sstart_o),
  .v_send_o  (v_send_o),
  .pol_o     (pol_o)
);

// File: tb/crt_timing_encoder_tb_top.sv
module crt_timing_encoder_tb_top;
  localparam int IN_W  = 10;
  localparam int MUL_W = 3;
  localparam int BRD_W = 3;
  localparam int OUT_W = 9;
  localparam int HW    = 7;
  localparam int VW    = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             start;
  logic [IN_W-1:0]  xres, hleft, hright, hsl, yres, vup, vlow, vsl;
  logic [MUL_W-1:0] hmul, hdiv, vmul, vdiv;
  logic [BRD_W-1:0] hbrd;
  logic             hpos, vpos;
  logic             busy, done, inval;
  logic [OUT_W-1:0] f [12];
  logic [7:0]       pol;

  crt_timing_encoder #(
    .IN_W (IN_W),
    .MUL_W(MUL_W),
    .BRD_W(BRD_W),
    .OUT_W(OUT_W),
    .FLD_W('{HW, HW, HW, HW, HW, HW, VW, VW, VW, VW, VW, VW})
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .xres_i(xres), .hleft_i(hleft), .hright_i(hright), .hsync_len_i(hsl),
    .yres_i(yres), .vupper_i(vup), .vlower_i(vlow), .vsync_len_i(vsl),
    .hmul_i(hmul), .hdiv_i(hdiv), .vmul_i(vmul), .vdiv_i(vdiv),
    .hborder_i(hbrd), .hsync_pos_i(hpos), .vsync_pos_i(vpos),
    .busy_o(busy), .done_o(done), .invalid_o(inval),
    .h_total_o(f[0]), .h_disp_o(f[1]), .h_bstart_o(f[2]), .h_bend_o(f[3]),
    .h_sstart_o(f[4]), .h_send_o(f[5]), .v_total_o(f[6]), .v_disp_o(f[7]),
    .v_bstart_o(f[8]), .v_bend_o(f[9]), .v_sstart_o(f[10]), .v_send_o(f[11]),
    .pol_o(pol)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int exp_f [12];
  int exp_pol = 0;
  bit exp_inv = 0;
  string inv_tag = "R9";

  string ftag [12] = '{"R2 R3", "R4", "R4", "R4", "R5", "R5",
                       "R6", "R6", "R6", "R6", "R7", "R7"};

  task automatic chk(string tag, string what, int got, int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, expv);
    end
  endtask

  function automatic int r8(int v);
    return ((v + 7) / 8) * 8;
  endfunction

  // reference model from the requirements
  task automatic model();
    int xr, hl, hr, hs, q[8], e[12];
    bit dz, zl, rg;
    xr = r8(int'(xres)); hl = r8(int'(hleft)); hr = r8(int'(hright)); hs = r8(int'(hsl));
    dz = (hdiv == 0) || (vdiv == 0);
    zl = ((hl + hr + hs) == 0) || (hs == 0) ||
         ((int'(vup) + int'(vlow) + int'(vsl)) == 0) || (vsl == 0);
    rg = 0;
    if (!dz) begin
      q[0] = (xr + hl + hr + hs) * int'(hmul) / int'(hdiv);
      q[1] = xr * int'(hmul) / int'(hdiv);
      q[2] = (xr + hr) * int'(hmul) / int'(hdiv);
      q[3] = (xr + hr + hs) * int'(hmul) / int'(hdiv);
      q[4] = (int'(yres) + int'(vup) + int'(vlow) + int'(vsl)) * int'(vmul) / int'(vdiv);
      q[5] = int'(yres) * int'(vmul) / int'(vdiv);
      q[6] = (int'(yres) + int'(vlow)) * int'(vmul) / int'(vdiv);
      q[7] = (int'(yres) + int'(vlow) + int'(vsl)) * int'(vmul) / int'(vdiv);
      e[0] = q[0] / 8 - 5;
      e[1] = q[1] / 8 - 1;
      e[2] = q[1] / 8 - 1 + int'(hbrd);
      e[3] = q[0] / 8 - 1 - int'(hbrd);
      e[4] = q[2] / 8;
      e[5] = q[3] / 8;
      e[6] = q[4] - 2;
      e[7] = q[5] - 1;
      e[8] = q[5];
      e[9] = q[4] - 2;
      e[10] = q[6];
      e[11] = q[7];
      for (int i = 0; i < 12; i++)
        if (e[i] < 0 || e[i] >= (1 << ((i < 6) ? HW : VW))) rg = 1;
    end
    exp_inv = dz || zl || rg;
    inv_tag = dz ? "R12" : (zl ? "R8" : "R9");
    if (!exp_inv) begin
      for (int i = 0; i < 12; i++) exp_f[i] = e[i];
      exp_pol = ((hpos ? 0 : 1) << 7) | ((vpos ? 0 : 1) << 6);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    do begin
      @(negedge clk);
      cycles++;
      n++;
    end while (!done && n < 2000);
    if (!done) chk("R13", "done never seen", 0, 1);
  endtask

  task automatic check_outputs();
    chk(inv_tag, "invalid", int'(inval), int'(exp_inv));
    for (int i = 0; i < 12; i++)
      chk(exp_inv ? "R10" : ftag[i], $sformatf("field%0d", i), int'(f[i]), exp_f[i]);
    chk(exp_inv ? "R10" : "R11", "pol", int'(pol), exp_pol);
  endtask

  task automatic run_case();
    model();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R13", "busy after start", int'(busy), 1);
    wait_done();
    check_outputs();
    @(negedge clk);
    chk("R13", "done one cycle", int'(done), 0);
  endtask

  initial begin
    int xr_l[4] = '{1, 9, 63, 700};
    int hl_l[2] = '{0, 16};
    int hr_l[3] = '{0, 3, 24};
    int hs_l[3] = '{0, 1, 8};
    int hm_l[4] = '{1, 3, 2, 5};
    int hd_l[4] = '{1, 2, 3, 0};
    int vm_l[5] = '{1, 2, 1, 3, 7};
    int vd_l[5] = '{1, 1, 2, 4, 3};
    int n = 0;
    start = 0; xres = 0; hleft = 0; hright = 0; hsl = 0; yres = 0; vup = 0;
    vlow = 0; vsl = 0; hmul = 0; hdiv = 0; vmul = 0; vdiv = 0; hbrd = 0;
    hpos = 0; vpos = 0;
    for (int i = 0; i < 12; i++) exp_f[i] = 0;

    repeat (3) @(negedge clk);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "invalid after reset", int'(inval), 0);
    chk("R1", "pol after reset", int'(pol), 0);
    for (int i = 0; i < 12; i++) chk("R1", $sformatf("field%0d reset", i), int'(f[i]), 0);

    // directed: a start while busy is ignored
    xres = 10'd40; hleft = 10'd8; hright = 10'd8; hsl = 10'd8;
    yres = 10'd100; vup = 10'd2; vlow = 10'd3; vsl = 10'd2;
    hmul = 3'd1; hdiv = 3'd1; vmul = 3'd1; vdiv = 3'd1; hbrd = 3'd1;
    hpos = 1'b1; vpos = 1'b0;
    model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    xres = 10'd63; yres = 10'd7; hpos = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    check_outputs();
    begin
      int extra = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R13", "start while busy ignored", extra, 0);
    end

    // sweep
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 3; c++)
          for (int d = 0; d < 3; d++)
            for (int s = 0; s < 4; s++)
              for (int br = 0; br < 2; br++) begin
                xres = IN_W'(xr_l[a]); hleft = IN_W'(hl_l[b] + c);
                hright = IN_W'(hr_l[c]); hsl = IN_W'(hs_l[d]);
                hmul = MUL_W'(hm_l[s]); hdiv = MUL_W'(hd_l[s]);
                hbrd = BRD_W'(br * 3);
                yres = IN_W'(1 + (n * 37) % 300);
                vup = IN_W'(n % 4); vlow = IN_W'((n / 3) % 5); vsl = IN_W'((n / 7) % 4);
                vmul = MUL_W'(vm_l[n % 5]); vdiv = MUL_W'(vd_l[n % 5]);
                hpos = n[0]; vpos = n[1];
                run_case();
                n++;
              end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cycles >= 0 && $time > 64'd3_800_000) begin
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule